// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block drives the external memory strobes of an 8-bit controller core that uses a 12-clock machine cycle. Each machine cycle splits into two 6-clock slots. In every slot the block pulses the address latch strobe for two clocks. During that pulse and the clock after it, it puts the low address byte on the shared address/data port. When the fetch goes to external program memory, it then asserts the program read strobe for three clocks and releases the shared port so that the memory can drive it. The high address byte is driven on the second port.

The core requests a data transfer by raising `movx_req` for the machine cycle that ends with `mc_last`. The block samples the request, the pointer, the pointer width, the direction and the write byte on that closing edge. The transfer then takes the next two machine cycles. The first cycle fetches normally in its first slot. In its second slot it latches the data address, with no program read. In the first slot of the second cycle no address latch strobe is issued, and the read or write strobe is held low instead. Normal fetching resumes in the second slot of the second cycle. An 8-bit pointer transfer shows the port 2 register on the high port in place of a high address byte. A strap selects whether low program addresses are served from on-chip memory. A control bit limits the address latch strobe to data transfers.

Top module: `ext_bus_seq`

## Requirements
- R1: With `ale_off` low and no transfer in progress, `ale` is high in machine-cycle phases 0-1 and 6-7 and low in all other phases. That gives two pulses of two clocks each per 12-clock cycle. Phase 0 is the clock after the edge on which `mc_last` was high.
- R2: During a transfer, `ale` is high in phases 6-7 of the first transfer cycle, while port 0 carries the data pointer low byte. `ale` is suppressed in phases 0-1 of the second transfer cycle.
- R3: For an external fetch, `psen_n` is low in slot phases 3-5 (machine phases 3-5 and 9-11). It stays high in the second slot of the first transfer cycle and in the first slot of the second transfer cycle, which drops two assertions per transfer.
- R4: `psen_n` stays high in any slot whose fetch address is served internally.
- R5: With `ale_off` high, `ale` is high only in phases 6-7 of a first transfer cycle.
- R6: In a fetch slot with an external fetch, `p0_out` carries the low byte of `pc` with `p0_oe` high in slot phases 0-2, and `p2_out` carries the high byte. In a slot with an internal fetch, `p2_out` shows `p2_reg` and `p0_oe` is low. `pc` is sampled at the edge that opens each slot.
- R7: In the two transfer slots, `p2_out` is the pointer high byte when `movx_wide` was 1 and `p2_reg` when it was 0.
- R8: A fetch is external when `ea` is 0, or when the slot address exceeds `INT_TOP` (default 0FFFH). Otherwise it is internal.
- R9: `rd_n` (for `movx_wr`=0) or `wr_n` (for `movx_wr`=1) is low in phases 0-4 of the second transfer cycle only, and the two are never low together. For a write, `p0_out` carries the write byte with `p0_oe` high from phase 9 of the first transfer cycle through phase 5 of the second.
- R10: `p0_oe` is low whenever `psen_n` or `rd_n` is low, and through the whole read data slot (phases 9-11 of the first transfer cycle and phases 0-5 of the second).
- R11: While `rst_n` is low, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `p0_oe` and `mc_last` are low, `p2_out` equals `p2_reg`, and the phase returns to 0.
- R12: `mc_last` is high in phase 11 only. A request is taken only on a phase-11 edge that does not close a first transfer cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | 16 | Program fetch address |
| movx_req | input | 1 | Data transfer request, sampled when `mc_last` is high |
| movx_wr | input | 1 | 1 selects a write, 0 a read |
| movx_wide | input | 1 | 1 selects a 16-bit pointer, 0 an 8-bit pointer |
| movx_ptr | input | 16 | Data pointer |
| movx_wdata | input | 8 | Write byte |
| p2_reg | input | 8 | Port 2 register value |
| ea | input | 1 | 1 lets low addresses fetch internally |
| ale_off | input | 1 | 1 limits ALE to transfers |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Port 0 address/data out |
| p0_oe | output | 1 | Port 0 output enable |
| p2_out | output | 8 | Port 2 output |
| mc_last | output | 1 | Last clock of a machine cycle |

## Verification
A wrong phase count or transfer flag moves a strobe edge. That shows up on `ale`, `psen_n`, `rd_n` or `wr_n` within the same clock, because all outputs are decoded directly from the registered state. A stale captured pointer or pc appears on `p0_out` or `p2_out` in the first address clock of the affected slot. A lost or doubled request shows up as a missing or extra dropped ALE pulse within one machine cycle. The bench compares every output on every clock against a model built from the phase rules, so any such fault is reported in the clock where it first appears.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter logic [15:0] INT_TOP = 16'h0FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] pc,
  input  logic        movx_req,
  input  logic        movx_wr,
  input  logic        movx_wide,
  input  logic [15:0] movx_ptr,
  input  logic [7:0]  movx_wdata,
  input  logic [7:0]  p2_reg,
  input  logic        ea,
  input  logic        ale_off,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  p0_out,
  output logic        p0_oe,
  output logic [7:0]  p2_out,
  output logic        mc_last
);

  localparam int unsigned LAST = 11;
  localparam int unsigned HALF = 6;

  logic [3:0]  ph;
  logic        m1, m2;
  logic [15:0] pcl, dptr;
  logic        dwr, dwide;
  logic [7:0]  dwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      m1    <= 1'b0;
      m2    <= 1'b0;
      pcl   <= '0;
      dptr  <= '0;
      dwr   <= 1'b0;
      dwide <= 1'b0;
      dwd   <= '0;
    end else begin
      ph <= (ph == 4'(LAST)) ? 4'd0 : ph + 4'd1;
      if (ph == 4'(LAST) || ph == 4'(HALF - 1)) pcl <= pc;
      if (ph == 4'(LAST)) begin
        m2 <= m1;
        m1 <= movx_req & ~m1;
        if (movx_req && !m1) begin
          dptr  <= movx_ptr;
          dwr   <= movx_wr;
          dwide <= movx_wide;
          dwd   <= movx_wdata;
        end
      end
    end
  end

  logic       hi;
  logic [3:0] sp;
  logic       aslot, dslot, mvx, ext;

  assign hi    = ph >= 4'(HALF);
  assign sp    = hi ? ph - 4'(HALF) : ph;
  assign aslot = m1 & hi;
  assign dslot = m2 & ~hi;
  assign mvx   = aslot | dslot;
  assign ext   = ~ea | (pcl > INT_TOP);

  logic       ale_i, psen_i, rd_i, wr_i, oe_i;
  logic [7:0] p0_i, p2_i;

  assign ale_i  = (sp < 4'd2) & ~dslot & (~ale_off | aslot);
  assign psen_i = (sp >= 4'd3) & ext & ~mvx;
  assign rd_i   = dslot & (ph <= 4'd4) & ~dwr;
  assign wr_i   = dslot & (ph <= 4'd4) & dwr;

  always_comb begin
    p0_i = pcl[7:0];
    oe_i = 1'b0;
    if (aslot && sp < 4'd3) begin
      p0_i = dptr[7:0];
      oe_i = 1'b1;
    end else if (mvx) begin
      p0_i = dwd;
      oe_i = dwr;
    end else if (sp < 4'd3) begin
      oe_i = ext;
    end
  end

  assign p2_i = mvx ? (dwide ? dptr[15:8] : p2_reg) : (ext ? pcl[15:8] : p2_reg);

  assign ale     = rst_n & ale_i;
  assign psen_n  = ~(rst_n & psen_i);
  assign rd_n    = ~(rst_n & rd_i);
  assign wr_n    = ~(rst_n & wr_i);
  assign p0_oe   = rst_n & oe_i;
  assign p0_out  = p0_i;
  assign p2_out  = rst_n ? p2_i : p2_reg;
  assign mc_last = rst_n & (ph == 4'(LAST));

  assert_rdwr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_wr_setup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> (p0_oe && $stable(p0_out)));
  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (p0_oe && $stable(p0_out)));
  assert_bus_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !p0_oe);
  assert_ale_psen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> psen_n);
  assert_ale_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);
  assert_ale_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |=> !ale);
  assert_no_strobe_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !ale);

endmodule

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] pc = '0;
  logic movx_req = 1'b0, movx_wr = 1'b0, movx_wide = 1'b0;
  logic [15:0] movx_ptr = '0;
  logic [7:0] movx_wdata = '0, p2_reg = 8'h5A;
  logic ea = 1'b1, ale_off = 1'b0;
  logic ale, psen_n, rd_n, wr_n, p0_oe, mc_last;
  logic [7:0] p0_out, p2_out;

  ext_bus_seq dut (.*);

  always #10 clk = ~clk;

  integer tests = 0, fails = 0, ticks = 0;
  logic [15:0] pc_base = 16'h0100;

  // reference model state
  integer mph = 0;
  bit mf1 = 0, mf2 = 0, mwr = 0, mwide = 0;
  logic [15:0] mpc = '0, mptr = '0;
  logic [7:0] mwd = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph = 0; mf1 = 0; mf2 = 0; mpc = '0; mptr = '0; mwr = 0; mwide = 0; mwd = '0;
    end else begin
      if (mph == 11 || mph == 5) mpc = pc;
      if (mph == 11) begin
        mf2 = mf1;
        if (movx_req && !mf1) begin
          mf1 = 1; mptr = movx_ptr; mwr = movx_wr; mwide = movx_wide; mwd = movx_wdata;
        end else mf1 = 0;
      end
      mph = (mph + 1) % 12;
    end
  end

  task automatic chk(input string tag, input integer act, input integer exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t phase=%0d actual=%0h expected=%0h", tag, $time, mph, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit first, dat, extf, e_ale, e_psen, e_rd, e_wr, e_oe;
    integer s;
    logic [7:0] e_p0, e_p2;
    if (!rst_n) begin
      chk("R11 ale", ale, 0); chk("R11 psen_n", psen_n, 1);
      chk("R11 rd_n", rd_n, 1); chk("R11 wr_n", wr_n, 1);
      chk("R11 p0_oe", p0_oe, 0); chk("R11 mc_last", mc_last, 0);
      chk("R11 p2_out", p2_out, p2_reg);
    end else begin
      s = mph % 6;
      first = mf1 && mph >= 6;
      dat = mf2 && mph < 6;
      extf = !ea || (mpc > 16'h0FFF);
      e_ale = (s < 2) && !dat && (ale_off ? first : 1'b1);
      e_psen = (s >= 3) && extf && !first && !dat;
      e_rd = dat && mph <= 4 && !mwr;
      e_wr = dat && mph <= 4 && mwr;
      e_oe = 0; e_p0 = 'x;
      if (first && s < 3) begin e_oe = 1; e_p0 = mptr[7:0]; end
      else if (first || dat) begin e_oe = mwr; e_p0 = mwd; end
      else if (s < 3 && extf) begin e_oe = 1; e_p0 = mpc[7:0]; end
      if (first || dat) e_p2 = mwide ? mptr[15:8] : p2_reg;
      else e_p2 = extf ? mpc[15:8] : p2_reg;
      chk(ale_off ? "R5 ale" : (first || dat) ? "R2 ale" : "R1 ale", ale, e_ale);
      chk((first || dat) ? "R3 psen_n" : extf ? "R8 psen_n" : "R4 psen_n", psen_n, !e_psen);
      chk("R9 rd_n", rd_n, !e_rd);
      chk("R9 wr_n", wr_n, !e_wr);
      chk((dat && !mwr) ? "R10 p0_oe" : "R6 p0_oe", p0_oe, e_oe);
      if (e_oe) chk((first || dat) ? "R9 p0_out" : "R6 p0_out", p0_out, e_p0);
      chk((first || dat) ? "R7 p2_out" : "R6 p2_out", p2_out, e_p2);
      chk("R12 mc_last", mc_last, mph == 11);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    ticks++;
    pc = {pc_base[15:2], 2'(ticks)};
  endtask

  task automatic mcycles(input integer n);
    repeat (n * 12) tick();
  endtask

  task automatic xfer(input bit wr, input bit wide, input logic [15:0] ptr, input logic [7:0] wd);
    movx_req = 1; movx_wr = wr; movx_wide = wide; movx_ptr = ptr; movx_wdata = wd;
    mcycles(1);
    movx_req = 0; movx_ptr = ~ptr; movx_wdata = ~wd;
    mcycles(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1;                       // R11 checked during reset above
    mcycles(2);                      // R4 internal fetch, R1 ALE rate
    pc_base = 16'h2000; mcycles(2);  // R8 above limit, R3 external PSEN
    pc_base = 16'h0FFC; mcycles(1);  // R8 boundary at 0FFFH
    ea = 0; pc_base = 16'h0200; mcycles(2);  // R8 strap low
    xfer(0, 1, 16'hA1B2, 8'h00);     // R2 R3 R9 R10 wide read
    xfer(1, 1, 16'hC3D4, 8'h96);     // R9 wide write
    ea = 1; pc_base = 16'h0040;
    xfer(0, 0, 16'h7788, 8'h00);     // R7 narrow read
    p2_reg = 8'h3C;
    xfer(1, 0, 16'h1122, 8'h69);     // R7 narrow write
    movx_req = 1; movx_wr = 1; movx_wide = 1; movx_ptr = 16'hBEEF; movx_wdata = 8'h42;
    mcycles(4);                      // R12 held request: taken every other cycle
    movx_req = 0; mcycles(2);
    ale_off = 1; pc_base = 16'h3000; mcycles(2);  // R5 no ALE without transfer
    xfer(0, 1, 16'h5566, 8'h00);     // R5 ALE only for transfer
    ale_off = 0; mcycles(1);
    rst_n = 0; mcycles(1);           // R11 mid-run reset
    rst_n = 1; mcycles(2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule